// File: doc/BRIEF.md
# Queue Interrupt Condition Controller

This block raises interrupts for 64 hardware queues. The queues are split into a lower half and an upper half of 32 queues each, and each half drives its own interrupt line. Every lower-half queue carries a 3-bit source code. The code picks one of four status flags (empty, nearly empty, nearly full, full) and can invert it. Every upper-half queue uses one fixed condition: the queue is not nearly empty, which means its nearly-empty flag is low.

The queue storage drives the status flags into the block, which registers them. A rising edge of a queue's selected condition, seen while that queue is enabled, sets a sticky pending bit. Software clears pending bits by writing ones to them. Each half also offers a read-only register that names its highest-numbered pending queue, so a handler can serve queues from the top down. Software reaches everything through a simple word-addressed register port. Reads from this port are combinational and writes take effect on the clock edge.

Top module: `qic_ctrl`

## Requirements
- R1: After reset, the registered flag views read as follows: lower empty all ones, lower nearly-empty all ones, lower nearly-full zero, lower full zero, upper nearly-empty all ones and upper full zero. Enables, pending bits, both interrupts and both top-pending registers read zero.
- R2: Source word k (address k, k=0..3) holds queues 8k..8k+7, with queue q in bits (q%8)*4+2 down to (q%8)*4. Code bits 1:0 select a flag: 0 empty, 1 nearly empty, 2 nearly full, 3 full. Code bit 2 inverts the selected flag. Bit 3 of each nibble is ignored on write and reads 0.
- R3: A rising edge of an enabled lower queue's selected condition sets its bit in the lower pending register (address 6). A held level does not set the bit again, and a change on a flag that is not selected has no effect.
- R4: Upper pending bit q (address 7) sets when upper nearly-empty input bit q falls while upper enable bit q is set. The upper full input never sets a pending bit.
- R5: A condition edge on a queue whose enable bit is clear does not set its pending bit.
- R6: Writing the pending registers clears every bit written as 1 and leaves every bit written as 0. Writing all ones clears the whole half.
- R7: If a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R8: Writing an enable register (lower at address 4, upper at address 5) with a bit changed from 1 to 0 also clears that queue's pending bit.
- R9: Each interrupt output is the OR of the enabled pending bits of its half. A flag input change becomes visible in the pending bits and the interrupt after the second rising clock edge.
- R10: The top-pending registers (lower at address 8, upper at address 9) show bit 31 set and bits 4:0 equal to the highest pending index when any bit is pending, and read zero otherwise.
- R11: The registered flag views sit at address 10 (lower empty), 11 (lower nearly empty), 12 (lower nearly full), 13 (lower full), 14 (upper nearly empty) and 15 (upper full). Each follows its input after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_empty_i | input | 32 | Lower-half empty flags |
| lo_nempty_i | input | 32 | Lower-half nearly-empty flags |
| lo_nfull_i | input | 32 | Lower-half nearly-full flags |
| lo_full_i | input | 32 | Lower-half full flags |
| hi_nempty_i | input | 32 | Upper-half nearly-empty flags |
| hi_full_i | input | 32 | Upper-half full flags |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_lo_o | output | 1 | Lower-half interrupt |
| irq_hi_o | output | 1 | Upper-half interrupt |

## Verification
Several lower queues are swept through all eight source codes. For each code the bench first toggles a flag that is not selected, then drives the selected flag from its false level to its true level. This separates decoding errors from inversion errors and from wrong nibble placement. Every upper queue is then driven one at a time, first by a full-flag toggle that must be ignored and then by a nearly-empty fall, which exposes any index or polarity mix-up. Further patterns cover several bits pending at once (for the highest-first order and clearing one bit at a time), a set that coincides with a clear, an edge on a disabled queue, and a disable while a bit is pending.

// File: rtl/qic_pkg.sv
package qic_pkg;
   localparam int SRC_W = 3;   // used bits of a source code
   localparam int NIB_W = 4;   // bits reserved per queue in a source word

   typedef enum logic [1:0] {
      FLG_EMPTY  = 2'd0,
      FLG_NEMPTY = 2'd1,
      FLG_NFULL  = 2'd2,
      FLG_FULL   = 2'd3
   } flag_sel_e;

   // flags ordered {full, nearly full, nearly empty, empty}
   function automatic logic cond_eval(input logic [3:0] flags, input logic [SRC_W-1:0] code);
      flag_sel_e sel;
      sel = flag_sel_e'(code[1:0]);
      return flags[sel] ^ code[2];
   endfunction
endpackage

// File: rtl/qic_src_decode.sv
module qic_src_decode #(
   parameter int N = 32
) (
   input  logic [N-1:0]                     emp_i,
   input  logic [N-1:0]                     nemp_i,
   input  logic [N-1:0]                     nful_i,
   input  logic [N-1:0]                     ful_i,
   input  logic [N-1:0][qic_pkg::SRC_W-1:0] src_i,
   output logic [N-1:0]                     cond_o
);
   for (genvar g = 0; g < N; g++) begin : g_q
      assign cond_o[g] = qic_pkg::cond_eval({ful_i[g], nful_i[g], nemp_i[g], emp_i[g]}, src_i[g]);
   end
endmodule

// File: rtl/qic_pend.sv
module qic_pend #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] w1c_i,
   input  logic [N-1:0] dis_i,
   output logic [N-1:0] stat_o,
   output logic         irq_o
);
   logic [N-1:0] prev_q, stat_q, set_w, stat_d;

   assign set_w  = cond_i & ~prev_q & en_i;
   assign stat_d = ((stat_q & ~w1c_i) | set_w) & ~dis_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= cond_i;
         stat_q <= stat_d;
      end
   end

   assign stat_o = stat_q;
   assign irq_o  = |(stat_q & en_i);

   // R6
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|w1c_i) |=> ((stat_q & $past(w1c_i & ~set_w)) == '0));
   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_w & w1c_i & ~dis_i)) |=>
      ((stat_q & $past(set_w & w1c_i & ~dis_i)) == $past(set_w & w1c_i & ~dis_i)));
   // R8
   dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dis_i) |=> ((stat_q & $past(dis_i)) == '0));
   // R5
   no_set_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_i)) == '0));
   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|set_w));
endmodule

// File: rtl/qic_prio.sv
module qic_prio #(
   parameter int N  = 32,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   output logic [IW-1:0] idx_o,
   output logic          valid_o
);
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end
   assign valid_o = |req_i;

   // R10
   prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ((req_i >> idx_o) == N'(1)));
   // R10
   prio_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (idx_o == '0 && req_i == '0));
endmodule

// File: rtl/qic_ctrl.sv
module qic_ctrl #(
   parameter int DW     = 32,
   parameter int HALF_Q = 32,
   parameter int AW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_Q-1:0] lo_empty_i,
   input  logic [HALF_Q-1:0] lo_nempty_i,
   input  logic [HALF_Q-1:0] lo_nfull_i,
   input  logic [HALF_Q-1:0] lo_full_i,
   input  logic [HALF_Q-1:0] hi_nempty_i,
   input  logic [HALF_Q-1:0] hi_full_i,
   input  logic              reg_we,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              irq_lo_o,
   output logic              irq_hi_o
);
   import qic_pkg::*;

   localparam int QPW  = DW / NIB_W;
   localparam int NSW  = HALF_Q / QPW;
   localparam int IW   = $clog2(HALF_Q);
   localparam int NREG = NSW + 12;
   localparam logic [AW-1:0] A_EN_LO  = AW'(NSW);
   localparam logic [AW-1:0] A_EN_HI  = AW'(NSW + 1);
   localparam logic [AW-1:0] A_ST_LO  = AW'(NSW + 2);
   localparam logic [AW-1:0] A_ST_HI  = AW'(NSW + 3);
   localparam logic [AW-1:0] A_TOP_LO = AW'(NSW + 4);
   localparam logic [AW-1:0] A_TOP_HI = AW'(NSW + 5);
   localparam logic [AW-1:0] A_F_LE   = AW'(NSW + 6);
   localparam logic [AW-1:0] A_F_LNE  = AW'(NSW + 7);
   localparam logic [AW-1:0] A_F_LNF  = AW'(NSW + 8);
   localparam logic [AW-1:0] A_F_LF   = AW'(NSW + 9);
   localparam logic [AW-1:0] A_F_HNE  = AW'(NSW + 10);
   localparam logic [AW-1:0] A_F_HF   = AW'(NSW + 11);

   if (DW % NIB_W != 0 || HALF_Q % QPW != 0 || HALF_Q > DW || (1 << AW) < NREG || IW >= DW - 1) begin : g_bad_cfg
      $error("qic_ctrl: inconsistent parameters");
   end

   // registered flag views
   logic [HALF_Q-1:0] lo_e_q, lo_ne_q, lo_nf_q, lo_f_q, hi_ne_q, hi_f_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_e_q  <= '1;
         lo_ne_q <= '1;
         lo_nf_q <= '0;
         lo_f_q  <= '0;
         hi_ne_q <= '1;
         hi_f_q  <= '0;
      end else begin
         lo_e_q  <= lo_empty_i;
         lo_ne_q <= lo_nempty_i;
         lo_nf_q <= lo_nfull_i;
         lo_f_q  <= lo_full_i;
         hi_ne_q <= hi_nempty_i;
         hi_f_q  <= hi_full_i;
      end
   end

   // source codes and enables
   logic [HALF_Q-1:0][SRC_W-1:0] src_q;
   logic [HALF_Q-1:0] en_lo_q, en_hi_q;
   logic [HALF_Q-1:0] wd_half;
   assign wd_half = reg_wdata[HALF_Q-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q   <= '0;
         en_lo_q <= '0;
         en_hi_q <= '0;
      end else if (reg_we) begin
         for (int w = 0; w < NSW; w++) begin
            if (reg_addr == AW'(w)) begin
               for (int j = 0; j < QPW; j++) begin
                  src_q[w*QPW + j] <= reg_wdata[j*NIB_W +: SRC_W];
               end
            end
         end
         if (reg_addr == A_EN_LO) en_lo_q <= wd_half;
         if (reg_addr == A_EN_HI) en_hi_q <= wd_half;
      end
   end

   logic [HALF_Q-1:0] w1c_lo, w1c_hi, dis_lo, dis_hi;
   assign w1c_lo = (reg_we && reg_addr == A_ST_LO) ? wd_half : '0;
   assign w1c_hi = (reg_we && reg_addr == A_ST_HI) ? wd_half : '0;
   assign dis_lo = (reg_we && reg_addr == A_EN_LO) ? (en_lo_q & ~wd_half) : '0;
   assign dis_hi = (reg_we && reg_addr == A_EN_HI) ? (en_hi_q & ~wd_half) : '0;

   // conditions
   logic [HALF_Q-1:0] cond_lo, cond_hi;
   qic_src_decode #(.N(HALF_Q)) u_dec (
      .emp_i (lo_e_q),
      .nemp_i(lo_ne_q),
      .nful_i(lo_nf_q),
      .ful_i (lo_f_q),
      .src_i (src_q),
      .cond_o(cond_lo)
   );
   assign cond_hi = ~hi_ne_q;

   // pending state and top-index per half
   logic [HALF_Q-1:0] st_lo, st_hi;
   logic [IW-1:0]     top_lo, top_hi;
   logic              vld_lo, vld_hi;

   qic_pend #(.N(HALF_Q)) u_pend_lo (
      .clk(clk), .rst_n(rst_n), .cond_i(cond_lo), .en_i(en_lo_q),
      .w1c_i(w1c_lo), .dis_i(dis_lo), .stat_o(st_lo), .irq_o(irq_lo_o)
   );
   qic_pend #(.N(HALF_Q)) u_pend_hi (
      .clk(clk), .rst_n(rst_n), .cond_i(cond_hi), .en_i(en_hi_q),
      .w1c_i(w1c_hi), .dis_i(dis_hi), .stat_o(st_hi), .irq_o(irq_hi_o)
   );
   qic_prio #(.N(HALF_Q)) u_prio_lo (
      .clk(clk), .rst_n(rst_n), .req_i(st_lo), .idx_o(top_lo), .valid_o(vld_lo)
   );
   qic_prio #(.N(HALF_Q)) u_prio_hi (
      .clk(clk), .rst_n(rst_n), .req_i(st_hi), .idx_o(top_hi), .valid_o(vld_hi)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      for (int w = 0; w < NSW; w++) begin
         if (reg_addr == AW'(w)) begin
            for (int j = 0; j < QPW; j++) begin
               reg_rdata[j*NIB_W +: SRC_W] = src_q[w*QPW + j];
            end
         end
      end
      unique case (reg_addr)
         A_EN_LO:  reg_rdata = DW'(en_lo_q);
         A_EN_HI:  reg_rdata = DW'(en_hi_q);
         A_ST_LO:  reg_rdata = DW'(st_lo);
         A_ST_HI:  reg_rdata = DW'(st_hi);
         A_TOP_LO: begin
            reg_rdata[DW-1]   = vld_lo;
            reg_rdata[IW-1:0] = top_lo;
         end
         A_TOP_HI: begin
            reg_rdata[DW-1]   = vld_hi;
            reg_rdata[IW-1:0] = top_hi;
         end
         A_F_LE:   reg_rdata = DW'(lo_e_q);
         A_F_LNE:  reg_rdata = DW'(lo_ne_q);
         A_F_LNF:  reg_rdata = DW'(lo_nf_q);
         A_F_LF:   reg_rdata = DW'(lo_f_q);
         A_F_HNE:  reg_rdata = DW'(hi_ne_q);
         A_F_HF:   reg_rdata = DW'(hi_f_q);
         default:  ;
      endcase
   end

   // R2
   src_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr < AW'(NSW)) |-> ((reg_rdata & {QPW{4'b1000}}) == '0));
endmodule

// File: tb/qic_ctrl_tb.sv
module qic_ctrl_tb;
   localparam logic [4:0] A_EN_LO = 5'd4, A_EN_HI = 5'd5, A_ST_LO = 5'd6, A_ST_HI = 5'd7;
   localparam logic [4:0] A_TOP_LO = 5'd8, A_TOP_HI = 5'd9;
   localparam logic [4:0] A_F_LE = 5'd10, A_F_LNE = 5'd11, A_F_LNF = 5'd12;
   localparam logic [4:0] A_F_LF = 5'd13, A_F_HNE = 5'd14, A_F_HF = 5'd15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] lo_e = '1, lo_ne = '1, lo_nf = '0, lo_f = '0, hi_ne = '1, hi_f = '0;
   logic reg_we = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic irq_lo, irq_hi;
   int checks = 0, failures = 0;
   logic [31:0] rv;

   always #5 clk = ~clk;

   qic_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .lo_empty_i(lo_e), .lo_nempty_i(lo_ne), .lo_nfull_i(lo_nf), .lo_full_i(lo_f),
      .hi_nempty_i(hi_ne), .hi_full_i(hi_f),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // all tasks are entered at a falling edge and return at a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic set_lo_flag(input int sel, input int q, input logic v);
      case (sel)
         0: lo_e[q]  = v;
         1: lo_ne[q] = v;
         2: lo_nf[q] = v;
         default: lo_f[q] = v;
      endcase
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int qs[4] = '{0, 5, 13, 31};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values, R11 flag view map
      rd(A_F_LE, rv);   check("R1 lo empty view", rv, 32'hFFFF_FFFF);
      rd(A_F_LNE, rv);  check("R1 lo nearly-empty view", rv, 32'hFFFF_FFFF);
      rd(A_F_LNF, rv);  check("R1 lo nearly-full view", rv, 32'h0);
      rd(A_F_LF, rv);   check("R1 lo full view", rv, 32'h0);
      rd(A_F_HNE, rv);  check("R1 hi nearly-empty view", rv, 32'hFFFF_FFFF);
      rd(A_F_HF, rv);   check("R1 hi full view", rv, 32'h0);
      rd(A_EN_LO, rv);  check("R1 lo enable", rv, 32'h0);
      rd(A_ST_LO, rv);  check("R1 lo pending", rv, 32'h0);
      rd(A_ST_HI, rv);  check("R1 hi pending", rv, 32'h0);
      rd(A_TOP_LO, rv); check("R1 lo top", rv, 32'h0);
      rd(A_TOP_HI, rv); check("R1 hi top", rv, 32'h0);
      check("R1 irq lo", {31'd0, irq_lo}, 32'h0);
      check("R1 irq hi", {31'd0, irq_hi}, 32'h0);
      @(negedge clk);

      // R11 flag view follows input after one edge
      lo_f = 32'h0000_0100;
      @(negedge clk);
      rd(A_F_LF, rv); check("R11 lo full view", rv, 32'h0000_0100);
      lo_f = '0;
      @(negedge clk);

      // R2, R3, R9, R10, R6: lower sweep over queues and all eight codes
      foreach (qs[k]) begin
         for (int code = 0; code < 8; code++) begin
            automatic int q = qs[k];
            automatic int sel = code & 3;
            automatic logic inv = code[2];
            automatic int nib = (q % 8) * 4;
            automatic logic [4:0] wa = 5'(q / 8);
            wr(A_EN_LO, 32'h0);
            wr(A_ST_LO, 32'hFFFF_FFFF);
            wr(wa, 32'(code | 8) << nib);
            rd(wa, rv); check("R2 source readback, reserved bit 0", rv, 32'(code) << nib);
            lo_e = '0; lo_ne = '0; lo_nf = '0; lo_f = '0;
            set_lo_flag(sel, q, inv);
            @(negedge clk);
            settle();
            wr(A_EN_LO, 32'h1 << q);
            set_lo_flag((sel + 1) % 4, q, 1'b1);
            settle();
            rd(A_ST_LO, rv); check("R3 unselected flag ignored", rv, 32'h0);
            set_lo_flag(sel, q, ~inv);
            settle();
            rd(A_ST_LO, rv); check("R3 selected condition edge sets", rv, 32'h1 << q);
            check("R9 irq lo on pending", {31'd0, irq_lo}, 32'h1);
            rd(A_TOP_LO, rv); check("R10 lo top index", rv, 32'h8000_0000 | 32'(q));
            wr(A_ST_LO, 32'h1 << q);
            rd(A_ST_LO, rv); check("R6 w1c clears lo bit", rv, 32'h0);
            check("R9 irq lo after clear", {31'd0, irq_lo}, 32'h0);
            settle();
            rd(A_ST_LO, rv); check("R3 held level no retrigger", rv, 32'h0);
         end
      end
      lo_e = '1; lo_ne = '1; lo_nf = '0; lo_f = '0;
      wr(A_EN_LO, 32'h0);
      settle();

      // R4, R6, R9, R10: upper sweep
      for (int q = 0; q < 32; q++) begin
         wr(A_EN_HI, 32'h1 << q);
         hi_f[q] = 1'b1;
         settle();
         rd(A_ST_HI, rv); check("R4 hi full ignored", rv, 32'h0);
         hi_ne[q] = 1'b0;
         settle();
         rd(A_ST_HI, rv); check("R4 hi not-nearly-empty sets", rv, 32'h1 << q);
         check("R9 irq hi on pending", {31'd0, irq_hi}, 32'h1);
         rd(A_TOP_HI, rv); check("R10 hi top index", rv, 32'h8000_0000 | 32'(q));
         if (q == 7) begin
            wr(A_ST_HI, 32'h0);
            rd(A_ST_HI, rv); check("R6 writing zero keeps bit", rv, 32'h1 << q);
         end
         hi_ne[q] = 1'b1; hi_f[q] = 1'b0;
         settle();
         wr(A_ST_HI, 32'hFFFF_FFFF);
         rd(A_ST_HI, rv); check("R6 all-ones clears half", rv, 32'h0);
         check("R9 irq hi after clear", {31'd0, irq_hi}, 32'h0);
      end

      // R5: edge on disabled queue
      wr(A_EN_HI, 32'h0);
      hi_ne[4] = 1'b0;
      settle();
      rd(A_ST_HI, rv); check("R5 disabled queue stays clear", rv, 32'h0);
      check("R5 irq hi stays low", {31'd0, irq_hi}, 32'h0);
      hi_ne[4] = 1'b1;
      settle();

      // R10 priority and R8 disable-clear
      wr(A_EN_HI, 32'hFFFF_FFFF);
      hi_ne[3] = 1'b0; hi_ne[9] = 1'b0; hi_ne[17] = 1'b0;
      settle();
      rd(A_ST_HI, rv);  check("R4 multiple pending", rv, 32'h0002_0208);
      rd(A_TOP_HI, rv); check("R10 highest of three", rv, 32'h8000_0011);
      wr(A_ST_HI, 32'h0002_0000);
      rd(A_TOP_HI, rv); check("R10 next highest", rv, 32'h8000_0009);
      wr(A_ST_HI, 32'h0000_0200);
      rd(A_TOP_HI, rv); check("R10 last pending", rv, 32'h8000_0003);
      wr(A_EN_HI, 32'hFFFF_FFF7);
      rd(A_ST_HI, rv); check("R8 disable clears pending", rv, 32'h0);
      check("R8 irq hi after disable", {31'd0, irq_hi}, 32'h0);
      rd(A_TOP_HI, rv); check("R10 none pending", rv, 32'h0);
      hi_ne = '1;
      wr(A_EN_HI, 32'h0);
      settle();

      // R7: set and clear in the same cycle
      wr(A_EN_LO, 32'h0);
      wr(5'd0, 32'h0000_0300);          // queue 2 selects full
      lo_f = '0;
      settle();
      wr(A_EN_LO, 32'h0000_0004);
      lo_f[2] = 1'b1;
      @(negedge clk);
      wr(A_ST_LO, 32'h0000_0004);
      rd(A_ST_LO, rv); check("R7 set wins over clear", rv, 32'h0000_0004);
      check("R7 irq lo stays high", {31'd0, irq_lo}, 32'h1);
      wr(A_EN_LO, 32'h0);
      rd(A_ST_LO, rv); check("R8 lo disable clears pending", rv, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule